// File: doc/BRIEF.md
# Burst Bus Transfer Sequencer

This block sits on the master side of a 32-bit-address system bus that several masters share. It takes one internal transfer request at a time and turns it into bus beats. It first raises a bus request to an external arbiter and waits for a grant. It then issues address phases and counts data beats. The slave stretches each beat with wait states by holding back its acknowledge.

A request is either a single access or a cache-line burst. The line is 32 bytes. A burst always moves the whole line, so its beat count depends on the configured data-bus width: four 64-bit beats, or eight 32-bit beats. A single access may be wider than the port it targets. In that case it is broken into narrower beats, and each narrower beat has its own address phase.

The response returns the gathered read data together with a one-cycle completion pulse. A burst aimed at a port narrower or wider than the bus is refused with an error flag, and the block does not touch the bus for it.

Top module: `bts_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_req`, `bus_ts` and `rsp_done` are 0.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 until that transfer completes. `bus_req` rises in the cycle after acceptance, and `bus_ts` never rises before a grant has been sampled.
- R3: A burst (`req_burst`=1) with `cfg_wide`=1 (64-bit bus) runs 4 beats. With `cfg_wide`=0 (32-bit bus) it runs 8 beats. It has one address phase, carrying the request address with its low 5 bits cleared, with `bus_burst`=1 and `bus_tsiz` equal to the bus width code. Size codes are 0=8, 1=16, 2=32 and 3=64 bits.
- R4: A burst whose `req_port` code differs from the bus width code (3 for a 64-bit bus, 2 for a 32-bit bus) gives `rsp_done`=1 with `rsp_err`=1 in the next cycle, and `bus_req` is never raised.
- R5: For a single access, the beat width code is the smallest of `req_size`, `req_port` and the bus width code, and the beat count is 2^(size - beat code). Each beat has its own address phase. Beat k uses address `req_addr` + k·(beat bytes), and `bus_tsiz` carries the beat code.
- R6: On a write, beat k drives bits [k·W +: W] of `req_wline` on the low W bits of `bus_wdata`, where W is the beat width in bits. The other bits of `bus_wdata` are 0. On a read, `bus_wdata` is all 0.
- R7: On a read, the low W bits of `bus_rdata` taken at beat k land in bits [k·W +: W] of `rsp_rline`. All other bits of `rsp_rline` are 0.
- R8: Outside its address phase, a beat holds `bus_addr` and `bus_wdata` stable until `bus_ack` is sampled. An acknowledge sampled while the block waits for grant or drives an address phase has no effect on the beat count.
- R9: In the cycle after the final acknowledge, `rsp_done` is 1, `bus_req` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 = 64-bit data bus, 0 = 32-bit data bus |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Idle, a request can be taken |
| req_addr | input | 32 | Byte address of the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code for single transfers |
| req_port | input | 2 | Port size code of the target region |
| req_burst | input | 1 | 1 = full-line burst |
| req_wline | input | 256 | Write data, beat 0 in the lowest bits |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused, valid with `rsp_done` |
| rsp_rline | output | 256 | Gathered read data, valid with `rsp_done` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_ts | output | 1 | Address phase strobe |
| bus_addr | output | 32 | Bus address |
| bus_write | output | 1 | Bus direction |
| bus_burst | output | 1 | Burst indicator for the address phase |
| bus_tsiz | output | 2 | Beat width code |
| bus_wdata | output | 64 | Write data of the current beat |
| bus_rdata | input | 64 | Read data from the slave |
| bus_ack | input | 1 | Slave transfer acknowledge |

## Verification
The bound checker watches several rules on every cycle. An address strobe only comes inside a bus tenure and never in its first cycle. The ready flag and the bus request never overlap. Address and write data stay still while a beat waits for its acknowledge. The request is released when completion is signalled, a refused burst never held the bus, and a burst always carries the bus-width size code. The bench scenarios cover the rest: beat counts, per-beat addresses, lane order of written and gathered data, and the fact that stray acknowledges and requests during a busy transfer do not shift the beat count.

// File: rtl/bts_pkg.sv
package bts_pkg;

    localparam logic [1:0] SZ_8  = 2'd0;
    localparam logic [1:0] SZ_16 = 2'd1;
    localparam logic [1:0] SZ_32 = 2'd2;
    localparam logic [1:0] SZ_64 = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } bts_state_e;

endpackage

// File: rtl/bts_plan.sv
module bts_plan
    import bts_pkg::*;
#(
    parameter int LINE_BYTES = 32,
    parameter int BEAT_W     = 3
) (
    input  logic              wide,
    input  logic [1:0]        size,
    input  logic [1:0]        port,
    input  logic              burst,
    output logic [1:0]        code,
    output logic [BEAT_W-1:0] last,
    output logic              reject
);
    localparam int WIDE_LAST   = LINE_BYTES / 8 - 1;
    localparam int NARROW_LAST = LINE_BYTES / 4 - 1;

    logic [1:0] bus_code;
    logic [1:0] eff_port;
    logic [1:0] single_code;
    logic [1:0] span;
    logic [3:0] split_cnt;

    always_comb begin
        bus_code    = wide ? SZ_64 : SZ_32;
        eff_port    = (port < bus_code) ? port : bus_code;
        single_code = (size < eff_port) ? size : eff_port;
        span        = size - single_code;
        split_cnt   = 4'd1 << span;
        if (burst) begin
            code   = bus_code;
            reject = (port != bus_code);
            last   = wide ? BEAT_W'(WIDE_LAST) : BEAT_W'(NARROW_LAST);
        end else begin
            code   = single_code;
            reject = 1'b0;
            last   = BEAT_W'(split_cnt - 4'd1);
        end
    end

endmodule

// File: rtl/bts_lane.sv
module bts_lane #(
    parameter int LINE_W = 256,
    parameter int BUS_W  = 64,
    parameter int BEAT_W = 3
) (
    input  logic [LINE_W-1:0] wline,
    input  logic [LINE_W-1:0] rline,
    input  logic [BEAT_W-1:0] beat,
    input  logic [1:0]        code,
    input  logic [BUS_W-1:0]  rdata,
    output logic [BUS_W-1:0]  wbeat,
    output logic [LINE_W-1:0] rline_next
);
    localparam int SH_W = $clog2(LINE_W) + 1;

    logic [SH_W-1:0]   shamt;
    logic [SH_W-1:0]   lane_bits;
    logic [BUS_W-1:0]  mask;
    logic [LINE_W-1:0] wshift;
    logic [LINE_W-1:0] rwide;

    always_comb begin
        lane_bits = SH_W'(8) << code;
        shamt     = SH_W'(beat) << (SH_W'(code) + SH_W'(3));
        if (code == 2'd3) begin
            mask = '1;
        end else begin
            mask = (BUS_W'(1) << lane_bits) - BUS_W'(1);
        end
        wshift     = wline >> shamt;
        wbeat      = wshift[BUS_W-1:0] & mask;
        rwide      = {{(LINE_W-BUS_W){1'b0}}, rdata & mask};
        rline_next = rline | (rwide << shamt);
    end

endmodule

// File: rtl/bts_sequencer.sv
module bts_sequencer
    import bts_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BUS_W      = 64,
    parameter int LINE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wide,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic [1:0]              req_size,
    input  logic [1:0]              req_port,
    input  logic                    req_burst,
    input  logic [LINE_BYTES*8-1:0] req_wline,
    output logic                    rsp_done,
    output logic                    rsp_err,
    output logic [LINE_BYTES*8-1:0] rsp_rline,
    output logic                    bus_req,
    input  logic                    bus_grant,
    output logic                    bus_ts,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic                    bus_write,
    output logic                    bus_burst,
    output logic [1:0]              bus_tsiz,
    output logic [BUS_W-1:0]        bus_wdata,
    input  logic [BUS_W-1:0]        bus_rdata,
    input  logic                    bus_ack
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BEAT_W = $clog2(LINE_BYTES / 4);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

    typedef struct packed {
        bts_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              burst;
        logic [1:0]        code;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] last;
        logic [LINE_W-1:0] wline;
        logic [LINE_W-1:0] rline;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [1:0]        plan_code;
    logic [BEAT_W-1:0] plan_last;
    logic              plan_reject;
    logic [BUS_W-1:0]  lane_wbeat;
    logic [LINE_W-1:0] lane_rline;

    bts_plan #(
        .LINE_BYTES (LINE_BYTES),
        .BEAT_W     (BEAT_W)
    ) u_plan (
        .wide   (cfg_wide),
        .size   (req_size),
        .port   (req_port),
        .burst  (req_burst),
        .code   (plan_code),
        .last   (plan_last),
        .reject (plan_reject)
    );

    bts_lane #(
        .LINE_W (LINE_W),
        .BUS_W  (BUS_W),
        .BEAT_W (BEAT_W)
    ) u_lane (
        .wline      (seq_q.wline),
        .rline      (seq_q.rline),
        .beat       (seq_q.beat),
        .code       (seq_q.code),
        .rdata      (bus_rdata),
        .wbeat      (lane_wbeat),
        .rline_next (lane_rline)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.rline = '0;
                    if (plan_reject) begin
                        seq_d.done = 1'b1;
                        seq_d.err  = 1'b1;
                    end else begin
                        seq_d.st    = ST_REQ;
                        seq_d.addr  = req_burst ? (req_addr & LINE_MASK) : req_addr;
                        seq_d.write = req_write;
                        seq_d.burst = req_burst;
                        seq_d.code  = plan_code;
                        seq_d.beat  = '0;
                        seq_d.last  = plan_last;
                        seq_d.wline = req_wline;
                    end
                end
            end
            ST_REQ: begin
                if (bus_grant) begin
                    seq_d.st = ST_ADDR;
                end
            end
            ST_ADDR: begin
                seq_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (bus_ack) begin
                    if (!seq_q.write) begin
                        seq_d.rline = lane_rline;
                    end
                    if (seq_q.beat == seq_q.last) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.beat = seq_q.beat + BEAT_W'(1);
                        if (!seq_q.burst) begin
                            seq_d.addr = seq_q.addr + (ADDR_W'(1) << seq_q.code);
                            seq_d.st   = ST_ADDR;
                        end
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign bus_req   = (seq_q.st != ST_IDLE);
    assign bus_ts    = (seq_q.st == ST_ADDR);
    assign bus_addr  = seq_q.addr;
    assign bus_write = seq_q.write;
    assign bus_burst = seq_q.burst;
    assign bus_tsiz  = seq_q.code;
    assign bus_wdata = seq_q.write ? lane_wbeat : '0;
    assign rsp_done  = seq_q.done;
    assign rsp_err   = seq_q.err;
    assign rsp_rline = seq_q.rline;

endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wide,
    input logic              req_ready,
    input logic              bus_req,
    input logic              bus_grant,
    input logic              bus_ts,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              bus_burst,
    input logic [1:0]        bus_tsiz,
    input logic              rsp_done,
    input logic              rsp_err
);

    AST_TS_IN_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |-> bus_req) else $error("ts outside tenure"); // R2

    AST_TS_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !bus_ts) else $error("ts before grant"); // R2

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req) else $error("ready while busy"); // R2

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ts && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata)))
        else $error("beat moved without ack"); // R8

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!bus_req && req_ready)) else $error("request held at done"); // R9

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> !$past(bus_req)) else $error("refused burst used bus"); // R4

    AST_BURST_TSIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ts && bus_burst) |-> (bus_tsiz == (cfg_wide ? 2'd3 : 2'd2)))
        else $error("burst size code"); // R3

    logic unused_grant;
    assign unused_grant = bus_grant;

endmodule

bind bts_sequencer bts_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/bts_sequencer_bench.sv
module bts_sequencer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wide = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_write = 1'b0;
    logic [1:0]   req_size = '0;
    logic [1:0]   req_port = '0;
    logic         req_burst = 1'b0;
    logic [255:0] req_wline = '0;
    logic         rsp_done, rsp_err;
    logic [255:0] rsp_rline;
    logic         bus_req, bus_ts, bus_write, bus_burst;
    logic         bus_grant = 1'b0;
    logic         bus_ack = 1'b0;
    logic [31:0]  bus_addr;
    logic [1:0]   bus_tsiz;
    logic [63:0]  bus_wdata;
    logic [63:0]  bus_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bts_sequencer u_bts_sequencer (.*);

    task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input int b, input int t);
        return {32'hC0DE0000 ^ 32'(b), 32'h5A5A0000 + 32'(b * 32'h1111) + 32'(t)};
    endfunction

    task automatic run_txn(input bit wide, input logic [1:0] size, input logic [1:0] port,
                           input bit burst, input bit write, input int t);
        logic [1:0]   bc, ep, w;
        logic [63:0]  mask, exp_w, md;
        logic [255:0] line, exp_r;
        logic [31:0]  base;
        bit rej, in_data, real_ack, granted, stray, junk, seen_done, any_req;
        int n, wb, beat, cyc, gdel, wt;
        bc   = wide ? 2'd3 : 2'd2;
        rej  = burst && (port != bc);
        ep   = (port < bc) ? port : bc;
        if (burst) begin
            w = bc;
            n = wide ? 4 : 8;
        end else begin
            w = (size < ep) ? size : ep;
            n = 1 << (size - w);
        end
        wb   = 8 << w;
        mask = (w == 2'd3) ? '1 : ((64'd1 << wb) - 64'd1);
        line = {64'h1111_2222_3333_4444 ^ 64'(t), 64'h5555_6666_7777_8888,
                64'h9999_AAAA_BBBB_CCCC, 64'hDDDD_EEEE_FFFF_0000 + 64'(t * 13)};
        base = 32'h1000_0000 + 32'(t * 64) + (burst ? 32'd8 : 32'd0);
        exp_r = '0;
        beat = 0; cyc = 0; gdel = t % 4; wt = t % 3;
        in_data = 0; real_ack = 0; granted = 0; seen_done = 0; any_req = 0;
        stray = t[0];
        junk  = t[1];
        cfg_wide = wide;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", 256'(req_ready), 256'd1);
        req_valid = 1'b1; req_addr = base; req_write = write; req_size = size;
        req_port = port; req_burst = burst; req_wline = line;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (real_ack) begin
                beat++;
                if (!burst) in_data = 0;
                wt = t % 3;
            end
            bus_ack = 1'b0; real_ack = 0; req_valid = 1'b0;
            if (rsp_done) begin seen_done = 1; break; end
            if (cyc > 300) break;
            if (bus_req) any_req = 1;
            if (junk) begin
                // R2: a request offered while busy must be ignored
                chk(req_ready == 1'b0, "R2 not ready while busy", 256'(req_ready), 256'd0);
                req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_burst = 1'b1; req_port = 2'd0;
            end
            bus_grant = 1'b0;
            if (bus_req) begin
                if (gdel == 0) begin bus_grant = 1'b1; granted = 1; end
                else gdel--;
            end
            if (in_data) begin
                if (wt == 0) begin
                    md = model(beat, t);
                    bus_ack = 1'b1; real_ack = 1; bus_rdata = md;
                    exp_w = write ? ((line >> (beat * wb)) & 256'(mask)) : 64'd0;
                    chk(bus_wdata == exp_w, "R6 write lane", 256'(bus_wdata), 256'(exp_w));
                    if (!write) exp_r = exp_r | (256'(md & mask) << (beat * wb));
                end else wt--;
            end else if (stray && bus_req) begin
                bus_ack = 1'b1; // R8 ack outside data phase has no effect
                bus_rdata = 64'hFFFF_FFFF_FFFF_FFFF;
            end
            if (bus_ts) begin
                chk(granted, "R2 ts after grant", 256'(granted), 256'd1);
                if (burst) begin
                    chk(beat == 0, "R3 single address phase", 256'(beat), 256'd0);
                    chk(bus_addr == (base & ~32'd31), "R3 burst address", 256'(bus_addr), 256'(base & ~32'd31));
                    chk(bus_burst == 1'b1, "R3 burst flag", 256'(bus_burst), 256'd1);
                    chk(bus_tsiz == bc, "R3 burst size code", 256'(bus_tsiz), 256'(bc));
                end else begin
                    chk(bus_addr == base + 32'(beat * (1 << w)), "R5 beat address",
                        256'(bus_addr), 256'(base + 32'(beat * (1 << w))));
                    chk(bus_tsiz == w, "R5 beat size code", 256'(bus_tsiz), 256'(w));
                end
                chk(bus_write == write, "R5 direction", 256'(bus_write), 256'(write));
                in_data = 1;
                wt = t % 3;
            end
        end
        bus_grant = 1'b0;
        chk(seen_done, "R9 completion seen", 256'(seen_done), 256'd1);
        chk(rsp_err == rej, "R4 error flag", 256'(rsp_err), 256'(rej));
        if (rej) begin
            chk(cyc == 1, "R4 refusal next cycle", 256'(cyc), 256'd1);
            chk(!any_req, "R4 no bus request", 256'(any_req), 256'd0);
        end else begin
            chk(beat == n, burst ? "R3 burst beat count" : "R5 split beat count", 256'(beat), 256'(n));
            chk(rsp_rline == exp_r, "R7 gathered read data", rsp_rline, exp_r);
            chk(bus_req == 1'b0 && req_ready == 1'b1, "R9 released at done",
                256'({bus_req, req_ready}), 256'b01);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int t;
        t = 0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && bus_req == 1'b0 && bus_ts == 1'b0 && rsp_done == 1'b0,
            "R1 in reset", 256'({req_ready, bus_req, bus_ts, rsp_done}), 256'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_req == 1'b0 && bus_ts == 1'b0 && rsp_done == 1'b0,
            "R1 after reset", 256'({req_ready, bus_req, bus_ts, rsp_done}), 256'b1000);
        for (int wd = 0; wd < 2; wd++)
            for (int bu = 0; bu < 2; bu++)
                for (int wr = 0; wr < 2; wr++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int pt = 0; pt < 4; pt++) begin
                            run_txn(wd[0], 2'(sz), 2'(pt), bu[0], wr[0], t);
                            t++;
                        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule